// File: doc/BRIEF.md
# Two-by-two cell routing element

This block is a 2×2 switching element for fixed-length cells. Two byte-wide lanes carry cells in lockstep under a shared start-of-cell strobe. On the first beat of each cell a decision stage reads header byte 0 of both lanes. It chooses one of two cross-connect settings. In the straight setting lane 0 goes to output 0 and lane 1 to output 1. In the swapped setting the two lanes trade outputs. The setting is registered and held until the next accepted start-of-cell beat, so every byte of a cell takes the same path.

Each lane passes through a two-beat alignment delay. Because of this delay the header bytes that were inspected reach the cross-connect together with the setting chosen from them. The valid and start-of-cell strobes are delayed by the same amount. When both cells ask for the same output, lane 0 gets it and the other cell is sent to the free output. A per-output misroute flag marks that cell.

The beat interface is valid/ready with a single shared handshake for both lanes. The whole pipeline advances only on beats where `out_ready` is high. `in_ready` follows `out_ready`. A beat is accepted when `in_valid` and `in_ready` are both high. While `out_ready` is low nothing moves and the outputs hold.

Top module: `cell_pair_switch`

## Requirements
- R1: After reset, `out_valid`, `out_sop` and `out_misroute` are all 0.
- R2: Setting 0 (straight) sends lane 0 to `out_lane0` and lane 1 to `out_lane1`. Setting 1 (swapped) sends lane 0 to `out_lane1` and lane 1 to `out_lane0`.
- R3: The setting is decided from header byte 0 of each lane, where bit 7 means the cell is active and bit 0 gives the requested output. When neither cell is active, the setting is straight.
- R4: When exactly one cell is active, the setting delivers that cell to the output named by its bit 0.
- R5: When both cells are active and want different outputs, each reaches its own output. When both want the same output, lane 0 gets it, lane 1 goes to the other output, and only that output's bit of `out_misroute` (bit i = output i) is set.
- R6: The setting holds for every byte after the header, whatever the values of bits 7 and 0 in those bytes.
- R7: A beat accepted at one clock appears on the outputs after two further pipeline advances. `out_valid` and `out_sop` are delayed by the same amount as the data.
- R8: `in_ready` equals `out_ready`. While `out_ready` is low, no beat is accepted and `out_valid`, `out_sop` and both output lanes hold their values.
- R9: A beat with `in_valid` low is a bubble. It reaches the output with `out_valid` low, and a start-of-cell strobe on it does not change the setting.
- R10: `out_misroute` is 0 whenever `out_valid` is low, and it stays constant over the valid beats of one cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Beat on both input lanes is present |
| in_ready | output | 1 | Element can take a beat (equals out_ready) |
| in_sop | input | 1 | Beat is header byte 0 of a new cell |
| in_lane0 | input | DATA_W | Input lane 0 byte |
| in_lane1 | input | DATA_W | Input lane 1 byte |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the output beat; advances the pipeline |
| out_sop | output | 1 | Output beat is the first byte of a cell |
| out_lane0 | output | DATA_W | Output 0 byte |
| out_lane1 | output | DATA_W | Output 1 byte |
| out_misroute | output | 2 | Bit i set: cell on output i lost contention |

## Verification
The bench covers all sixteen combinations of the two activity bits and two destination bits. This separates the idle default from the single-active cases and from the clash and no-clash cases with two active cells. Each combination is sent once with `out_ready` always high and once with a periodic stall pattern that can also fall on the header beat. The stalled run shows that held beats are neither lost nor duplicated and that the setting latches only on an accepted header. Payload bytes vary bits 7 and 0 to show that the setting holds through the cell. A mid-cell bubble carrying a conflicting strobe and header shows that invalid beats are ignored.

// File: rtl/cpr_pkg.sv
package cpr_pkg;

  // Cross-connect setting
  typedef enum logic {
    XC_BAR   = 1'b0,
    XC_CROSS = 1'b1
  } xc_state_e;

  // Per-cell control word: setting plus per-output misroute marks
  typedef struct packed {
    xc_state_e  state;
    logic [1:0] mis;
  } xc_ctl_t;

endpackage

// File: rtl/cpr_decide.sv
module cpr_decide
  import cpr_pkg::*;
(
  input  logic    act0,
  input  logic    dst0,
  input  logic    act1,
  input  logic    dst1,
  output xc_ctl_t ctl
);

  always_comb begin
    ctl.state = XC_BAR;
    ctl.mis   = 2'b00;
    unique case ({act0, act1})
      2'b10: ctl.state = dst0 ? XC_CROSS : XC_BAR;
      2'b01: ctl.state = dst1 ? XC_BAR : XC_CROSS;
      2'b11: begin
        // lane 0 always gets its requested output
        ctl.state = dst0 ? XC_CROSS : XC_BAR;
        if (dst0 == dst1) begin
          // lane 1 lands on the output lane 0 did not take
          ctl.mis = dst0 ? 2'b01 : 2'b10;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cpr_delay.sv
module cpr_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int LAST = DEPTH - 1;

  logic [W-1:0] pipe [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  pipe[s] <= '0;
        else if (en) pipe[s] <= d;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  pipe[s] <= '0;
        else if (en) pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[LAST];

endmodule

// File: rtl/cpr_xconnect.sv
module cpr_xconnect
  import cpr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  xc_state_e         state,
  input  logic [DATA_W-1:0] a0,
  input  logic [DATA_W-1:0] a1,
  output logic [DATA_W-1:0] y0,
  output logic [DATA_W-1:0] y1
);

  always_comb begin
    if (state == XC_CROSS) begin
      y0 = a1;
      y1 = a0;
    end else begin
      y0 = a0;
      y1 = a1;
    end
  end

endmodule

// File: rtl/cell_pair_switch.sv
module cell_pair_switch
  import cpr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ACT_BIT = 7,
  parameter int DST_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sop,
  input  logic [DATA_W-1:0] in_lane0,
  input  logic [DATA_W-1:0] in_lane1,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sop,
  output logic [DATA_W-1:0] out_lane0,
  output logic [DATA_W-1:0] out_lane1,
  output logic [1:0]        out_misroute
);

  localparam int LANES       = 2;
  localparam int ALIGN_DEPTH = 2;
  localparam int CTL_W       = $bits(xc_ctl_t);

  logic              adv;
  logic              take_sop;
  logic [DATA_W-1:0] lane_in  [LANES];
  logic [DATA_W-1:0] lane_dly [LANES];
  logic [1:0]        flags_dly;
  xc_ctl_t           dec;
  xc_ctl_t           ctl_hold;
  logic [CTL_W-1:0]  ctl_out_bits;
  xc_ctl_t           ctl_out;

  assign adv      = out_ready;
  assign in_ready = out_ready;
  assign take_sop = in_valid & in_sop;

  assign lane_in[0] = in_lane0;
  assign lane_in[1] = in_lane1;

  // Header decision
  cpr_decide u_decide (
    .act0 (in_lane0[ACT_BIT]),
    .dst0 (in_lane0[DST_BIT]),
    .act1 (in_lane1[ACT_BIT]),
    .dst1 (in_lane1[DST_BIT]),
    .ctl  (dec)
  );

  // Setting latch: loads on an accepted header beat, holds otherwise
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_hold <= '{state: XC_BAR, mis: 2'b00};
    end else if (adv && take_sop) begin
      ctl_hold <= dec;
    end
  end

  // Carry the setting the rest of the way alongside its data
  cpr_delay #(.W(CTL_W), .DEPTH(ALIGN_DEPTH - 1)) u_ctl_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .d     (ctl_hold),
    .q     (ctl_out_bits)
  );
  assign ctl_out = xc_ctl_t'(ctl_out_bits);

  // Per-lane alignment delay
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    cpr_delay #(.W(DATA_W), .DEPTH(ALIGN_DEPTH)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (adv),
      .d     (lane_in[l]),
      .q     (lane_dly[l])
    );
  end

  // Strobe delay, matched to the data
  cpr_delay #(.W(2), .DEPTH(ALIGN_DEPTH)) u_flag_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .d     ({in_valid, take_sop}),
    .q     (flags_dly)
  );

  cpr_xconnect #(.DATA_W(DATA_W)) u_xc (
    .state (ctl_out.state),
    .a0    (lane_dly[0]),
    .a1    (lane_dly[1]),
    .y0    (out_lane0),
    .y1    (out_lane1)
  );

  assign out_valid    = flags_dly[1];
  assign out_sop      = flags_dly[0];
  assign out_misroute = ctl_out.mis & {2{flags_dly[1]}};

endmodule

// File: rtl/cpr_switch_chk.sv
module cpr_switch_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_sop,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_sop,
  input logic [DATA_W-1:0] out_lane0,
  input logic [DATA_W-1:0] out_lane1,
  input logic [1:0]        out_misroute
);

  AST_SOP_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> out_valid); // R7

  AST_SOP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sop && out_ready) ##1 out_ready |=> out_sop); // R7

  AST_BUBBLE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) ##1 out_ready |=> !out_valid); // R9

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sop) &&
      $stable(out_lane0) && $stable(out_lane1))); // R8

  AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_misroute)); // R5

  AST_MIS_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_misroute) |-> out_valid); // R10

  AST_MIS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop && $past(out_valid)) |->
      out_misroute == $past(out_misroute)); // R10

endmodule

bind cell_pair_switch cpr_switch_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/cell_pair_switch_tb_top.sv
module cell_pair_switch_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CELL_BYTES = 53;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_sop = 1'b0;
  logic [7:0] in_lane0 = '0;
  logic [7:0] in_lane1 = '0;
  logic       out_ready = 1'b1;
  logic       in_ready;
  logic       out_valid;
  logic       out_sop;
  logic [7:0] out_lane0;
  logic [7:0] out_lane1;
  logic [1:0] out_misroute;

  int n_chk = 0;
  int n_bad = 0;
  int beat_no = 0;

  // expected pipeline (stage 1 / stage 2) and current cell setting
  logic       e1_v = 0, e1_sop = 0, e2_v = 0, e2_sop = 0;
  logic [7:0] e1_d0 = 0, e1_d1 = 0, e2_d0 = 0, e2_d1 = 0;
  logic [1:0] e1_mis = 0, e2_mis = 0;
  string      e1_tag = "R3", e2_tag = "R3";
  logic       cur_x = 0;
  logic [1:0] cur_mis = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cell_pair_switch dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_sop       (in_sop),
    .in_lane0     (in_lane0),
    .in_lane1     (in_lane1),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_sop      (out_sop),
    .out_lane0    (out_lane0),
    .out_lane1    (out_lane1),
    .out_misroute (out_misroute)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s beat %0d: got %h expected %h", tag, beat_no, got, exp);
    end
  endtask

  // {swapped, misroute[1:0]} worked out from the header rules
  function automatic logic [2:0] ref_decide(input logic [7:0] h0, input logic [7:0] h1);
    logic a0, a1, d0, d1;
    a0 = h0[7]; d0 = h0[0]; a1 = h1[7]; d1 = h1[0];
    if (a0 && a1)
      return {d0, (d0 == d1) ? 2'(1 << (1 - int'(d0))) : 2'b00};
    else if (a0)
      return {d0, 2'b00};
    else if (a1)
      return {~d1, 2'b00};
    return 3'b000;
  endfunction

  task automatic step(input logic v, input logic s, input logic [7:0] a,
                      input logic [7:0] b, input logic rdy, input string tag);
    logic [2:0] d;
    chk("R7 valid", out_valid, e2_v);
    chk("R7 sop", out_sop, e2_sop);
    chk("R10 misroute", out_misroute, e2_v ? e2_mis : 2'b00);
    if (e2_v) begin
      chk("R2 out_lane0", out_lane0, e2_d0);
      chk({e2_tag, " out_lane1"}, out_lane1, e2_d1);
    end
    in_valid = v; in_sop = s; in_lane0 = a; in_lane1 = b; out_ready = rdy;
    #1;
    chk("R8 in_ready", in_ready, rdy);
    if (rdy) begin
      if (v && s) begin
        d = ref_decide(a, b);
        cur_x = d[2];
        cur_mis = d[1:0];
      end
      e2_v = e1_v; e2_sop = e1_sop; e2_d0 = e1_d0; e2_d1 = e1_d1;
      e2_mis = e1_mis; e2_tag = e1_tag;
      e1_v = v; e1_sop = v & s;
      e1_d0 = cur_x ? b : a;
      e1_d1 = cur_x ? a : b;
      e1_mis = cur_mis; e1_tag = tag;
    end
    beat_no++;
    @(negedge clk);
  endtask

  task automatic send_cell(input logic [7:0] h0, input logic [7:0] h1, input int k,
                           input string tag, input bit stall, input int bubble_at);
    int i = 0;
    while (i < CELL_BYTES) begin
      logic       rdy;
      logic [7:0] a, b;
      rdy = !stall || (beat_no % 3 != 1);
      a = (i == 0) ? h0 : 8'(k * 37 + i * 11);
      b = (i == 0) ? h1 : 8'(k * 53 + i * 29 + 101);
      if (i == bubble_at) begin
        // invalid beat with a conflicting header and strobe: must be ignored
        step(1'b0, 1'b1, ~h0, ~h1, 1'b1, "R9");
      end
      step(1'b1, i == 0, a, b, rdy, (i == 0) ? tag : "R6");
      if (rdy) i++;
    end
  endtask

  task automatic sweep(input bit stall);
    for (int c = 0; c < 16; c++) begin
      logic [7:0] h0, h1;
      string      tag;
      h0 = {c[3], 6'(c + 5), c[2]};
      h1 = {c[1], 6'(c * 3), c[0]};
      if (c[3] && c[1])      tag = "R5";
      else if (c[3] || c[1]) tag = "R4";
      else                   tag = "R3";
      if (stall) tag = {tag, "/R8"};
      send_cell(h0, h1, c + (stall ? 16 : 0), tag, stall, -1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", out_valid, 1'b0);
    chk("R1 sop", out_sop, 1'b0);
    chk("R1 misroute", out_misroute, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", out_valid, 1'b0);

    sweep(1'b0);
    sweep(1'b1);

    // R9: bubble mid-cell, lane 0 active to output 1, lane 1 idle
    send_cell(8'h81, 8'h00, 40, "R4", 1'b0, 20);
    // R5: clash toward output 0, then a bubble right after the header
    send_cell(8'h80, 8'h82, 41, "R5", 1'b0, 1);

    for (int j = 0; j < 4; j++) step(1'b0, 1'b0, 8'h00, 8'h00, 1'b1, "R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule